// File: doc/BRIEF.md
# Short/Long Button Press Classifier

The block watches three active-high push buttons (left, middle and right). Each input is brought into the clock domain through a two-flop synchroniser. It is then debounced against a millisecond tick supplied from outside. The block measures how long the first qualifying button stays down and reduces the press to a three-bit event code. The code says which button was used and whether the hold was short or long. A host reads that code from an 8-bit status byte, and the read clears it.

A long hold is reported as soon as the threshold is crossed, while the button is still down. A short hold is reported when the button is released. Either way each press is reported once. A long hold of the middle button also raises a one-cycle menu request pulse. While one button is being tracked, other buttons are ignored until every button is up again.

Top module: `btn_press_classifier`

## Requirements
- R1: After reset the status byte reads 0x00 and menu_req is low.
- R2: A short left press produces code 3'b010 and a long left press produces 3'b011 in status bits [2:0].
- R3: A short middle press produces code 3'b100 and a long middle press produces 3'b101.
- R4: A short right press produces code 3'b110 and a long right press produces 3'b111. Bit 0 of the code is the long flag.
- R5: A press held for LONG_MS ticks after debouncing is reported at the threshold, before the button is released.
- R6: menu_req is a single-cycle pulse that fires exactly once for each long middle press and never for any other event.
- R7: Status bits [7:3] always read zero, and code 3'b001 is never produced.
- R8: A host read (rd_stb high for one cycle) clears the code to 3'b000 on the next cycle, unless a new event lands in that same cycle, in which case the new event is kept.
- R9: A level change that lasts fewer than DEBOUNCE_MS consecutive ticks is ignored and produces no event.
- R10: When several buttons go down together, the lowest index wins (left over middle over right). Once a button is being tracked, other buttons are ignored until all buttons are released.
- R11: Each press is reported at most once. Releasing a button after its long report produces no further event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| btn_in | input | 3 | Raw buttons, active high: [0] left, [1] middle, [2] right |
| rd_stb | input | 1 | Host read strobe for the status byte |
| status_q | output | 8 | Status byte: [2:0] event code, [7:3] zero |
| menu_req | output | 1 | One-cycle pulse on a long middle press |

## Verification
The bench builds the block with DEBOUNCE_MS=3 and LONG_MS=20, and it drives ms_tick every fourth clock. With these values a long hold and its early report take only a few hundred cycles, which puts every code, the menu pulse and the threshold-before-release case within reach. The small debounce window also makes a sub-window glitch easy to build from whole ticks. Simultaneous and overlapping presses are driven on purpose, so that the lowest-index priority and the ignore-until-all-released rule are both observed at the status byte.

// File: rtl/btn_evt_pkg.sv
// Shared types and helpers for the button press classifier.
package btn_evt_pkg;
    localparam int NUM_BTN  = 3;
    localparam int CODE_W   = 3;
    localparam int STATUS_W = 8;
    localparam int ID_W     = $clog2(NUM_BTN);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HELD = 2'd1,
        ST_DRAIN = 2'd2
    } trk_state_e;

    // Event code: button number (index+1) in the upper two bits, long flag in bit 0.
    function automatic logic [CODE_W-1:0] make_code(input logic [ID_W-1:0] id,
                                                    input logic is_long);
        logic [1:0] num;
        num = 2'(id) + 2'd1;
        return {num, is_long};
    endfunction
endpackage

// File: rtl/btn_filter.sv
// Synchroniser and debounce for one raw button.
// Assumes: tick_i is a single-cycle pulse. The filtered level follows the
// synchronised input only after DEBOUNCE_MS consecutive ticks of disagreement.
module btn_filter #(
    parameter int DEBOUNCE_MS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_i,
    output logic level_o
);
    localparam int CNT_W = $clog2(DEBOUNCE_MS + 1);

    logic [1:0]       sync_q;
    logic             filt_q;
    logic [CNT_W-1:0] cnt_q;

    // Two-flop synchroniser for the asynchronous button.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], raw_i};
    end

    // Count ticks of disagreement and accept the new level when the window fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else if (sync_q[1] == filt_q) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == CNT_W'(DEBOUNCE_MS - 1)) begin
                filt_q <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level_o = filt_q;

    // R9
    filt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> $past(tick_i));
endmodule

// File: rtl/press_tracker.sv
// Selects the first qualifying button, times its hold in ticks and emits one
// event per press. Assumes levels are already debounced.
module press_tracker
    import btn_evt_pkg::*;
#(
    parameter int LONG_MS = 700
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic [NUM_BTN-1:0]    level_i,
    output logic                  evt_vld_o,
    output logic [CODE_W-1:0]     evt_code_o
);
    localparam int DUR_W = $clog2(LONG_MS + 1);

    trk_state_e       state_q;
    logic [ID_W-1:0]  sel_q;
    logic [DUR_W-1:0] dur_q;
    logic [ID_W-1:0]  first_id;
    logic             sel_down;
    logic             hit_long;

    // Lowest-index pressed button has priority.
    always_comb begin
        first_id = '0;
        for (int i = NUM_BTN - 1; i >= 0; i--) begin
            if (level_i[i]) first_id = ID_W'(i);
        end
    end

    assign sel_down = level_i[sel_q];
    assign hit_long = tick_i && (dur_q == DUR_W'(LONG_MS - 1));

    // Tracking state machine with hold-duration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sel_q      <= '0;
            dur_q      <= '0;
            evt_vld_o  <= 1'b0;
            evt_code_o <= '0;
        end else begin
            evt_vld_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (|level_i) begin
                        sel_q   <= first_id;
                        dur_q   <= '0;
                        state_q <= ST_HELD;
                    end
                end
                ST_HELD: begin
                    if (!sel_down) begin
                        evt_vld_o  <= 1'b1;
                        evt_code_o <= make_code(sel_q, 1'b0);
                        state_q    <= ST_DRAIN;
                    end else if (hit_long) begin
                        evt_vld_o  <= 1'b1;
                        evt_code_o <= make_code(sel_q, 1'b1);
                        state_q    <= ST_DRAIN;
                    end else if (tick_i) begin
                        dur_q <= dur_q + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (!(|level_i)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R11
    one_evt_per_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vld_o |-> (state_q == ST_DRAIN));

    // R10
    drain_until_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_DRAIN && state_q == ST_IDLE) |-> !(|$past(level_i)));
endmodule

// File: rtl/event_status.sv
// Holds the last event code for the host, clears it on read and pulses the
// menu request on a long middle press.
module event_status
    import btn_evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_vld_i,
    input  logic [CODE_W-1:0]   evt_code_i,
    input  logic                rd_stb_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                menu_o
);
    localparam logic [CODE_W-1:0] MENU_CODE = 3'b101;

    logic [CODE_W-1:0] code_q;
    logic              menu_q;

    // Latch a new event; otherwise a host read clears the code.
    always_ff @(posedge clk) begin
        if (!rst_n)         code_q <= '0;
        else if (evt_vld_i) code_q <= evt_code_i;
        else if (rd_stb_i)  code_q <= '0;
    end

    // One-cycle menu request alongside a long middle event.
    always_ff @(posedge clk) begin
        if (!rst_n) menu_q <= 1'b0;
        else        menu_q <= evt_vld_i && (evt_code_i == MENU_CODE);
    end

    assign status_o = {{(STATUS_W - CODE_W){1'b0}}, code_q};
    assign menu_o   = menu_q;

    // R7
    no_code_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_q != 3'b001);

    // R6
    menu_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        menu_q |=> !menu_q);

    // R6
    menu_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        menu_q |-> (code_q == MENU_CODE));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !evt_vld_i) |=> (code_q == '0));
endmodule

// File: rtl/btn_press_classifier.sv
// Top: three debounced buttons classified into a short/long event code,
// readable by a host and cleared on read. Assumes ms_tick pulses once per ms.
module btn_press_classifier
    import btn_evt_pkg::*;
#(
    parameter int DEBOUNCE_MS = 10,
    parameter int LONG_MS     = 700
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ms_tick,
    input  logic [2:0]          btn_in,
    input  logic                rd_stb,
    output logic [7:0]          status_q,
    output logic                menu_req
);
    logic [NUM_BTN-1:0] level;
    logic               evt_vld;
    logic [CODE_W-1:0]  evt_code;

    // One filter per button.
    for (genvar g = 0; g < NUM_BTN; g++) begin : g_flt
        btn_filter #(.DEBOUNCE_MS(DEBOUNCE_MS)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (ms_tick),
            .raw_i   (btn_in[g]),
            .level_o (level[g])
        );
    end

    press_tracker #(.LONG_MS(LONG_MS)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (ms_tick),
        .level_i    (level),
        .evt_vld_o  (evt_vld),
        .evt_code_o (evt_code)
    );

    event_status u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_vld_i  (evt_vld),
        .evt_code_i (evt_code),
        .rd_stb_i   (rd_stb),
        .status_o   (status_q),
        .menu_o     (menu_req)
    );
endmodule

// File: tb/btn_press_classifier_test.sv
module btn_press_classifier_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int DEB        = 3;
    localparam int LONG       = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic [2:0] btn_in = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] status_q;
    logic       menu_req;

    int n_checks = 0;
    int n_fail   = 0;
    int menu_cnt = 0;
    logic [2:0] exp_q[$];

    btn_press_classifier #(.DEBOUNCE_MS(DEB), .LONG_MS(LONG)) uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .btn_in(btn_in),
        .rd_stb(rd_stb), .status_q(status_q), .menu_req(menu_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Millisecond tick generator.
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected codes as events appear, then read to clear.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (menu_req) menu_cnt++;
                check(status_q[7:3] == 5'd0, "R7 upper bits", status_q, status_q[2:0]);
                if (rd_stb) begin
                    rd_stb = 1'b0;
                end else if (status_q[2:0] != 3'b000) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R11 unexpected event", status_q[2:0], 0);
                    end else begin
                        logic [2:0] e;
                        e = exp_q.pop_front();
                        check(status_q[2:0] == e, "R2/R3/R4/R10 code", status_q[2:0], e);
                    end
                    rd_stb = 1'b1;
                end
            end
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    // Driver: one press of mask held for hold ticks; expected code queued first.
    task automatic press(input logic [2:0] mask, input int hold, input logic [2:0] exp,
                         input bit is_long);
        int m0;
        m0 = menu_cnt;
        exp_q.push_back(exp);
        btn_in = mask;
        wait_ticks(hold);
        if (is_long)
            check(exp_q.size() == 0, "R5 long reported while held", exp_q.size(), 0);
        btn_in = '0;
        wait_ticks(DEB + 6);
        check(exp_q.size() == 0, "R11 event consumed once", exp_q.size(), 0);
        check(menu_cnt - m0 == ((exp == 3'b101) ? 1 : 0), "R6 menu pulse count",
              menu_cnt - m0, (exp == 3'b101) ? 1 : 0);
        check(status_q == 8'h00, "R8 read clears", status_q, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(status_q == 8'h00, "R1 status after reset", status_q, 0);
        check(menu_req == 1'b0, "R1 menu after reset", menu_req, 0);
        rst_n = 1'b1;
        wait_ticks(2);

        // R9: glitch of two ticks, shorter than the debounce window.
        btn_in = 3'b010;
        repeat (2 * TICK_DIV) @(negedge clk);
        btn_in = '0;
        wait_ticks(DEB + 6);
        check(status_q == 8'h00 && exp_q.size() == 0, "R9 glitch ignored", status_q, 0);
        check(menu_cnt == 0, "R9 no menu on glitch", menu_cnt, 0);

        press(3'b001, 8,  3'b010, 1'b0);  // R2 short
        press(3'b001, 32, 3'b011, 1'b1);  // R2 long
        press(3'b010, 8,  3'b100, 1'b0);  // R3 short
        press(3'b010, 32, 3'b101, 1'b1);  // R3 long, R6 menu
        press(3'b100, 8,  3'b110, 1'b0);  // R4 short
        press(3'b100, 32, 3'b111, 1'b1);  // R4 long
        press(3'b101, 8,  3'b010, 1'b0);  // R10 left beats right together
        press(3'b110, 32, 3'b101, 1'b1);  // R10 middle beats right, long

        // R10: right first, left joins, right released, left released later.
        exp_q.push_back(3'b110);
        btn_in = 3'b100;
        wait_ticks(6);
        btn_in = 3'b101;
        wait_ticks(6);
        btn_in = 3'b001;
        wait_ticks(DEB + 6);
        check(exp_q.size() == 0, "R10 tracked button reported", exp_q.size(), 0);
        btn_in = '0;
        wait_ticks(DEB + 6);
        check(status_q == 8'h00, "R10 late button ignored", status_q, 0);

        wait_ticks(4);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule